// File: doc/BRIEF.md
# Transmit Bit Request Retimer

This block sits between a host controller and a frequency-shift modulator. It takes transmit data one bit at a time over a request and strobe handshake, and it sends those bits on to the modulator at an exact bit period counted from the system clock. The bit timing therefore comes from the block's own clock and not from the uneven timing of host software.

While transmit is enabled and the block has room for a bit, it holds the active-low request output low. The host then places a bit on the data input and pulses the strobe. The block latches the bit on the strobe's rising edge and raises the request. At the next bit-period boundary the latched bit moves to the modulator output, where it stays for exactly one period, and the request drops again. The host therefore has a whole bit period to supply the next bit, and no gap appears between bits. If the host misses a boundary, the output idles at mark (logic 1) and a sticky underrun flag rises. The strobe and data inputs are asynchronous, so both pass through a two-stage synchronizer. A rate input chooses between the fast and the slow bit period, and each period is a parameter counted in system clocks.

Top module: `tx_bit_retimer`

## Requirements
- R1: After reset, `mod_bit` is 1 (mark), `req_n` is 1 and `underrun` is 0.
- R2: While `tx_en` is 0, the registered outputs go to `mod_bit`=1, `req_n`=1 and `underrun`=0 one cycle later, and strobes and data have no effect on any output.
- R3: When `tx_en` is first seen high and no bit is waiting, `req_n` goes low on the next clock edge.
- R4: A bit is latched from `host_bit` on a rising edge of `host_strobe`. `host_bit` must be stable from 2 cycles before that edge until 2 cycles after it. `req_n` goes high exactly 3 clock edges after the strobe rises.
- R5: A latched bit appears on `mod_bit` at the next bit-period boundary and is held for one full period. `req_n` falls in the same cycle that the bit appears.
- R6: A bit period is FAST_CYC clocks when `rate_slow`=0 and SLOW_CYC clocks when `rate_slow`=1.
- R7: A strobe rising edge seen while `req_n` is high is ignored: the bit already waiting is the one that is sent.
- R8: If a boundary passes with no bit waiting after at least one bit has been sent since enable, `mod_bit` goes to 1 and `underrun` goes to 1 at that boundary. `underrun` stays 1 until `tx_en` drops. Before the first bit, idle boundaries do not set `underrun`.
- R9: Period boundaries start counting at enable. The first boundary falls the given number of period clocks after the first cycle in which `tx_en` is high.
- R10: Dropping `tx_en` discards a waiting bit. After re-enable, that bit is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| rate_slow | input | 1 | 0 selects the fast bit period, 1 selects the slow one |
| host_strobe | input | 1 | Host latch strobe (asynchronous), latches on its rising edge |
| host_bit | input | 1 | Host transmit bit (asynchronous) |
| req_n | output | 1 | Active-low request for the next bit |
| mod_bit | output | 1 | Retimed bit to the modulator, mark when idle |
| underrun | output | 1 | Sticky flag: a boundary passed with no bit waiting |

## Verification
The bench builds the block with FAST_CYC=12 and SLOW_CYC=40 instead of the real divider values. At these values the full 5-bit pattern sweep (160 bits back to back), the underrun boundary and a slow-rate stream all fit in a few thousand cycles. The short periods also let every shift event be timed to the exact cycle against a period computed in the bench. The handshake latency, the ignored strobe and the dropped waiting bit then each fall within a single period.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } rate_e;

    typedef struct packed {
        logic out_bit;     // bit presented to the modulator
        logic req_n;       // active-low request to the host
        logic pend_valid;  // a bit is waiting for the next boundary
        logic pend_bit;    // the waiting bit
        logic started;     // at least one bit emitted since enable
        logic underrun;    // sticky starvation flag
        logic stb_prev;    // synchronized strobe, one cycle old
    } tbr_state_t;

    localparam tbr_state_t TBR_RESET = '{
        out_bit:    1'b1,
        req_n:      1'b1,
        pend_valid: 1'b0,
        pend_bit:   1'b0,
        started:    1'b0,
        underrun:   1'b0,
        stb_prev:   1'b0
    };

endpackage

// File: rtl/tbr_sync.sv
module tbr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/tbr_bit_timer.sv
module tbr_bit_timer #(
    parameter int FAST_CYC = 3072,
    parameter int SLOW_CYC = 49152
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rate_slow,
    output logic tick
);

    localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CYC - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last  = rate_slow ? SLOW_LAST : FAST_LAST;
        tick  = run && (cnt_q >= last);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tx_bit_retimer.sv
module tx_bit_retimer
    import tbr_pkg::*;
#(
    parameter int FAST_CYC    = 3072,
    parameter int SLOW_CYC    = 49152,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic rate_slow,
    input  logic host_strobe,
    input  logic host_bit,
    output logic req_n,
    output logic mod_bit,
    output logic underrun
);

    logic       stb_s, bit_s;
    logic       tick;
    logic       stb_rise;
    tbr_state_t st_d, st_q;

    tbr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_strobe, host_bit}),
        .q     ({stb_s, bit_s})
    );

    tbr_bit_timer #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (tx_en),
        .rate_slow (rate_slow),
        .tick      (tick)
    );

    assign stb_rise = stb_s & ~st_q.stb_prev;

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb_s;
        if (!tx_en) begin
            st_d.out_bit    = 1'b1;
            st_d.req_n      = 1'b1;
            st_d.pend_valid = 1'b0;
            st_d.pend_bit   = 1'b0;
            st_d.started    = 1'b0;
            st_d.underrun   = 1'b0;
        end else begin
            // boundary first: it sees only the bit waiting before this cycle
            if (tick) begin
                if (st_q.pend_valid) begin
                    st_d.out_bit    = st_q.pend_bit;
                    st_d.pend_valid = 1'b0;
                    st_d.started    = 1'b1;
                end else begin
                    st_d.out_bit = 1'b1;
                    if (st_q.started) st_d.underrun = 1'b1;
                end
            end
            // a strobe counts only while the request is being made
            if (stb_rise && !st_q.pend_valid) begin
                st_d.pend_valid = 1'b1;
                st_d.pend_bit   = bit_s;
            end
            st_d.req_n = st_d.pend_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TBR_RESET;
        else        st_q <= st_d;
    end

    assign req_n    = st_q.req_n;
    assign mod_bit  = st_q.out_bit;
    assign underrun = st_q.underrun;

endmodule

// File: rtl/tx_bit_retimer_chk.sv
module tx_bit_retimer_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic tick,
    input logic stb_rise,
    input logic req_n,
    input logic mod_bit,
    input logic underrun
);

    assert_idle_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (mod_bit && req_n && !underrun));

    assert_change_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && (mod_bit != $past(mod_bit))) |-> $past(tick));

    assert_req_rise_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_n) && $past(tx_en)) |-> $past(stb_rise));

    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && $past(underrun)) |-> underrun);

    assert_req_after_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_en && tick && !stb_rise) |-> !req_n);

endmodule

bind tx_bit_retimer tx_bit_retimer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .tick     (tick),
    .stb_rise (stb_rise),
    .req_n    (req_n),
    .mod_bit  (mod_bit),
    .underrun (underrun)
);

// File: tb/tx_bit_retimer_tb.sv
`timescale 1ns/1ps
module tx_bit_retimer_tb;

    localparam int FAST = 12;
    localparam int SLOW = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic rate_slow = 1'b0;
    logic host_strobe = 1'b0;
    logic host_bit = 1'b0;
    logic req_n, mod_bit, underrun;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // monitor state
    bit exp_q[$];
    bit mon_on = 1'b0;
    bit contig = 1'b0;
    bit prev_req = 1'b1;
    int last_t = 0;
    int per = FAST;
    bit last_sent = 1'b0;

    tx_bit_retimer #(.FAST_CYC(FAST), .SLOW_CYC(SLOW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rate_slow(rate_slow),
        .host_strobe(host_strobe), .host_bit(host_bit),
        .req_n(req_n), .mod_bit(mod_bit), .underrun(underrun)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // shift events: req_n falling while bits are outstanding
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_req && !req_n && exp_q.size() > 0) begin
                check(mod_bit == exp_q[0], "R5 emitted bit", mod_bit, exp_q[0]);
                if (contig)
                    check(cyc - last_t == per, "R6/R9 boundary spacing", cyc - last_t, per);
                last_t = cyc;
                void'(exp_q.pop_front());
            end
            prev_req = req_n;
        end
    end

    task automatic send_bit(input bit b);
        int t0;
        while (req_n) @(negedge clk);
        host_bit = b;
        tick_n(2);
        host_strobe = 1'b1;
        t0 = cyc;
        exp_q.push_back(b);
        last_sent = b;
        tick_n(2);
        check(req_n == 1'b0, "R4 req still low 2 edges after strobe", req_n, 0);
        tick_n(1);
        check(req_n == 1'b1, "R4 req high 3 edges after strobe", req_n, 1);
        host_strobe = 1'b0;
        tick_n(1);
    endtask

    task automatic start_tx(input bit slow);
        rate_slow = slow;
        per = slow ? SLOW : FAST;
        exp_q.delete();
        prev_req = req_n;
        tx_en = 1'b1;
        last_t = cyc;
        contig = 1'b1;
        mon_on = 1'b1;
        tick_n(1);
        check(req_n == 1'b0, "R3 request after enable", req_n, 0);
    endtask

    initial begin
        tick_n(3);
        // R1 reset state
        check(mod_bit == 1'b1, "R1 mod_bit reset", mod_bit, 1);
        check(req_n == 1'b1, "R1 req_n reset", req_n, 1);
        check(underrun == 1'b0, "R1 underrun reset", underrun, 0);
        rst_n = 1'b1;
        tick_n(2);

        // R2 strobes ignored while disabled
        for (int k = 0; k < 4; k++) begin
            host_bit = 1'b0;
            host_strobe = 1'b1;
            tick_n(4);
            host_strobe = 1'b0;
            tick_n(4);
        end
        tick_n(30);
        check(mod_bit == 1'b1, "R2 mod_bit idle while disabled", mod_bit, 1);
        check(req_n == 1'b1, "R2 req_n high while disabled", req_n, 1);
        check(underrun == 1'b0, "R2 underrun clear while disabled", underrun, 0);

        // fast stream: all 5-bit patterns, LSB first
        start_tx(1'b0);
        for (int p = 0; p < 32; p++)
            for (int j = 0; j < 5; j++)
                send_bit(p[j]);

        // R7 strobe while request is high is ignored
        send_bit(1'b0);
        host_bit = 1'b1;
        tick_n(1);
        host_strobe = 1'b1;
        tick_n(3);
        check(req_n == 1'b1, "R7 req stays high on extra strobe", req_n, 1);
        host_strobe = 1'b0;
        tick_n(1);
        send_bit(1'b1);
        send_bit(1'b0);

        // R8 underrun: wait for last bit to appear, then one period
        while (exp_q.size() > 0) begin
            @(negedge clk);
            #1;
        end
        tick_n(FAST - 1);
        check(mod_bit == last_sent, "R8 last bit held full period", mod_bit, last_sent);
        check(underrun == 1'b0, "R8 no underrun before boundary", underrun, 0);
        tick_n(1);
        check(mod_bit == 1'b1, "R8 mark after starvation", mod_bit, 1);
        check(underrun == 1'b1, "R8 underrun set at boundary", underrun, 1);
        tick_n(2 * FAST);
        check(underrun == 1'b1, "R8 underrun sticky", underrun, 1);

        // R2 disable clears
        tx_en = 1'b0;
        mon_on = 1'b0;
        tick_n(1);
        check(underrun == 1'b0, "R2 underrun cleared on disable", underrun, 0);
        check(req_n == 1'b1, "R2 req_n high on disable", req_n, 1);
        check(mod_bit == 1'b1, "R2 mark on disable", mod_bit, 1);
        tick_n(3);

        // R6 slow rate stream
        start_tx(1'b1);
        for (int j = 0; j < 8; j++)
            send_bit(((8'hB4 >> j) & 8'h01) != 0);
        while (exp_q.size() > 0) begin
            @(negedge clk);
            #1;
        end

        // R10 waiting bit discarded by disable
        send_bit(1'b0);
        tx_en = 1'b0;
        mon_on = 1'b0;
        exp_q.delete();
        tick_n(1);
        check(mod_bit == 1'b1, "R10 mark after mid-stream disable", mod_bit, 1);
        check(req_n == 1'b1, "R10 req high after mid-stream disable", req_n, 1);
        tick_n(2);
        tx_en = 1'b1;
        tick_n(1);
        check(req_n == 1'b0, "R10 request after re-enable", req_n, 0);
        for (int k = 0; k < 3 * SLOW; k++) begin
            @(negedge clk);
            if (mod_bit != 1'b1) begin
                check(1'b0, "R10 dropped bit emitted", mod_bit, 1);
                break;
            end
        end
        check(mod_bit == 1'b1, "R10 output stays mark", mod_bit, 1);
        check(underrun == 1'b0, "R8 idle boundaries before first bit", underrun, 0);

        done = 1'b1;
    end

    initial begin
        for (int w = 0; w < 150000; w++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule